// File: doc/BRIEF.md
# Indirect Command-Word Peripheral Bus Bridge

This block lets a host reach a simple 32-bit-address peripheral bus through three 64-bit registers. The host places write data in a data register, then writes a control word. That control write launches exactly one access on the peripheral side. The access runs as a request/acknowledge handshake with byte-lane enables. The host learns the outcome by reading a status word. That word carries busy, done, error flags and, for reads, the returned data.

All field positions in this brief use most-significant-first numbering: bit 0 is the MSB of a 64-bit word, and bit n sits at vector index 63-n. The register offsets are 0 for control, 2 for status and 3 for write data. Offset 1 reads as zero.

Each control word carries the following fields:
- Bits 0-3: a key nibble, which must be 0xD.
- Bits 4-7: the size in bytes, which must be 1, 2 or 4.
- Bit 15: the read flag (1 = read).
- Bits 23-25: the address-length code, which must be 4.
- Bits 32-63: the target address.

The status word carries the following fields:
- Bit 0: bus error.
- Bits 6-37: read data, left-justified.
- Bit 44: busy.
- Bit 45: bad key.
- Bit 46: bad size.
- Bit 47: bad address-length code.
- Bit 52: done.
- Every other bit reads zero.

Reading offset 0 returns the last accepted control word. Reading offset 3 returns the data register.

Top module: `cmdbus_bridge`

## Requirements
- R1: After reset, `busReq` is 0, and the status word and the data register both read as zero.
- R2: A control write with key 0xD, a legal size and address-length code 4 that arrives while idle has these effects from the next cycle: `busReq` is 1, status busy (bit 44) is 1, done (bit 52) is 0, `busAddr` equals control bits 32-63, and `busWe` is the inverse of bit 15.
- R3: Byte enables are left-justified by size: size 1 gives 4'b1000, size 2 gives 4'b1100 and size 4 gives 4'b1111. `busWdata` equals data-register bits 0-31, as held at launch.
- R4: `busReq` and `busAddr` stay stable until `busAck` is sampled. At that edge busy clears and done sets.
- R5: For a successful read, status bits 6-37 hold `busRdata` for the enabled lanes only; the unused low lanes read zero. For a write or a failed access, the field is zero.
- R6: An idle control write with a wrong key, an illegal size or an address-length code other than 4 starts no access. From the next cycle it sets done and the matching error bit: 45 for the key, 46 for the size, 47 for the address-length code.
- R7: A `busErr` sampled with `busAck` sets status bit 0 and still sets done.
- R8: A control write that arrives while busy is ignored. The running access keeps its address, and no second access follows.
- R9: Done and the error bits hold until the next accepted control write, which clears them. Busy and done are never set together.
- R10: Data-register writes during an access do not change the running access's `busWdata`, and the new value reads back at offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostAddr | input | 2 | Host register offset |
| hostWdata | input | 64 | Host write data |
| hostRdata | output | 64 | Register read data for `hostAddr` (combinational) |
| busReq | output | 1 | Access request, held until acknowledge |
| busWe | output | 1 | 1 = write access |
| busAddr | output | 32 | Target address |
| busByteEn | output | 4 | Left-justified byte-lane enables |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with `busAck` |
| busAck | input | 1 | Access complete |
| busErr | input | 1 | Error response, valid with `busAck` |

## Verification
The bench sweeps all sixteen size codes in both directions with varying acknowledge latency. A design that misdecoded the size would launch an access for an illegal size, or use the wrong lane mask. A design that packed read data right-justified, or left stale high-lane bytes in place, would show the wrong status field for 1- and 2-byte reads.

A second control word is sent while an access is still running. A design that accepted it would move the address or run a second access. The data register is rewritten in the middle of an access. A design that drove the live register onto the bus would show the new data.

Error paths are exercised one at a time: a bad key, a bad address-length code and a bus error response. A design that dropped done on an error, or failed to clear stale errors on the next command, would report the wrong flags.

// File: rtl/cmdbus_bridge_pkg.sv
package cmdbus_bridge_pkg;
  localparam int WORD_W    = 64;
  localparam int BUS_AW    = 32;
  localparam int BUS_DW    = 32;
  localparam int BUS_BYTES = BUS_DW / 8;

  // register offsets
  localparam int OFS_CTL  = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_DATA = 3;

  localparam logic [3:0] CMD_KEY   = 4'hD;
  localparam logic [2:0] ALEN_FULL = 3'd4;

  // control word fields (vector indices of MSB-first bit numbers)
  localparam int KEY_HI  = WORD_W - 1;
  localparam int KEY_LO  = WORD_W - 4;
  localparam int SIZE_HI = WORD_W - 5;
  localparam int SIZE_LO = WORD_W - 8;
  localparam int RD_BIT  = WORD_W - 16;
  localparam int ALEN_HI = WORD_W - 24;
  localparam int ALEN_LO = WORD_W - 26;

  // status word fields
  localparam int ST_BUSERR = WORD_W - 1;
  localparam int RDF_HI    = WORD_W - 7;
  localparam int RDF_LO    = WORD_W - 38;
  localparam int ST_BUSY   = WORD_W - 45;
  localparam int ST_KEY    = WORD_W - 46;
  localparam int ST_SIZE   = WORD_W - 47;
  localparam int ST_ALEN   = WORD_W - 48;
  localparam int ST_DONE   = WORD_W - 53;

  typedef struct packed {
    logic launch;
    logic reject;
    logic badKey;
    logic badSize;
    logic badAlen;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/cmdbus_bridge_ctrl.sv
module cmdbus_bridge_ctrl
  import cmdbus_bridge_pkg::*;
#(
  parameter int HOST_AW = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [3:0]         cmdKey,
  input  logic [3:0]         cmdSize,
  input  logic [2:0]         cmdAlen,
  input  logic               busAck,
  output logic               busy,
  output strobe_t            strobe
);
  logic ctlHit, accept, keyOk, sizeOk, alenOk, allOk;

  always_comb begin
    ctlHit = hostWe && (hostAddr == HOST_AW'(OFS_CTL));
    accept = ctlHit && !busy;
    keyOk  = (cmdKey == CMD_KEY);
    sizeOk = (cmdSize == 4'd1) || (cmdSize == 4'd2) || (cmdSize == 4'd4);
    alenOk = (cmdAlen == ALEN_FULL);
    allOk  = keyOk && sizeOk && alenOk;

    strobe.launch  = accept && allOk;
    strobe.reject  = accept && !allOk;
    strobe.badKey  = accept && !keyOk;
    strobe.badSize = accept && !sizeOk;
    strobe.badAlen = accept && !alenOk;
    strobe.finish  = busy && busAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busy <= 1'b0;
    else if (strobe.launch) busy <= 1'b1;
    else if (strobe.finish) busy <= 1'b0;
  end
endmodule

// File: rtl/cmdbus_bridge_dp.sv
module cmdbus_bridge_dp
  import cmdbus_bridge_pkg::*;
#(
  parameter int HOST_AW = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic                 busy,
  input  logic                 hostWe,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic [WORD_W-1:0]    hostWdata,
  input  logic [BUS_DW-1:0]    busRdata,
  input  logic                 busErr,
  output logic [BUS_AW-1:0]    busAddr,
  output logic                 busWe,
  output logic [BUS_BYTES-1:0] busByteEn,
  output logic [BUS_DW-1:0]    busWdata,
  output logic [WORD_W-1:0]    statusWord,
  output logic [WORD_W-1:0]    hostRdata
);
  logic [WORD_W-1:0] ctlReg, dataReg;
  logic [BUS_DW-1:0] rdField, rdMask;
  logic              doneR, errBus, errKey, errSize, errAlen;
  logic [3:0]        sizeR;

  assign sizeR    = ctlReg[SIZE_HI:SIZE_LO];
  assign busAddr  = ctlReg[BUS_AW-1:0];
  assign busWe    = !ctlReg[RD_BIT];

  always_comb begin
    for (int i = 0; i < BUS_BYTES; i++)
      busByteEn[BUS_BYTES-1-i] = (i < int'(sizeR));
  end

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    assign rdMask[8*g +: 8] = {8{busByteEn[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg   <= '0;
      dataReg  <= '0;
      busWdata <= '0;
      rdField  <= '0;
      doneR    <= 1'b0;
      errBus   <= 1'b0;
      errKey   <= 1'b0;
      errSize  <= 1'b0;
      errAlen  <= 1'b0;
    end else begin
      if (hostWe && hostAddr == HOST_AW'(OFS_DATA))
        dataReg <= hostWdata;
      if (strobe.launch || strobe.reject) begin
        ctlReg  <= hostWdata;
        doneR   <= strobe.reject;
        errBus  <= 1'b0;
        errKey  <= strobe.badKey;
        errSize <= strobe.badSize;
        errAlen <= strobe.badAlen;
        rdField <= '0;
      end
      if (strobe.launch)
        busWdata <= dataReg[WORD_W-1 -: BUS_DW];
      if (strobe.finish) begin
        doneR  <= 1'b1;
        errBus <= busErr;
        if (ctlReg[RD_BIT] && !busErr)
          rdField <= busRdata & rdMask;
      end
    end
  end

  always_comb begin
    statusWord                = '0;
    statusWord[ST_BUSERR]     = errBus;
    statusWord[RDF_HI:RDF_LO] = rdField;
    statusWord[ST_BUSY]       = busy;
    statusWord[ST_KEY]        = errKey;
    statusWord[ST_SIZE]       = errSize;
    statusWord[ST_ALEN]       = errAlen;
    statusWord[ST_DONE]       = doneR;
  end

  always_comb begin
    case (hostAddr)
      HOST_AW'(OFS_CTL):  hostRdata = ctlReg;
      HOST_AW'(OFS_STAT): hostRdata = statusWord;
      HOST_AW'(OFS_DATA): hostRdata = dataReg;
      default:            hostRdata = '0;
    endcase
  end
endmodule

// File: rtl/cmdbus_bridge.sv
module cmdbus_bridge
  import cmdbus_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [1:0]  hostAddr,
  input  logic [63:0] hostWdata,
  output logic [63:0] hostRdata,
  output logic        busReq,
  output logic        busWe,
  output logic [31:0] busAddr,
  output logic [3:0]  busByteEn,
  output logic [31:0] busWdata,
  input  logic [31:0] busRdata,
  input  logic        busAck,
  input  logic        busErr
);
  strobe_t     strobe;
  logic        busy;
  logic [63:0] statusWord;

  cmdbus_bridge_ctrl #(.HOST_AW(2)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .cmdKey   (hostWdata[KEY_HI:KEY_LO]),
    .cmdSize  (hostWdata[SIZE_HI:SIZE_LO]),
    .cmdAlen  (hostWdata[ALEN_HI:ALEN_LO]),
    .busAck   (busAck),
    .busy     (busy),
    .strobe   (strobe)
  );

  cmdbus_bridge_dp #(.HOST_AW(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busy       (busy),
    .hostWe     (hostWe),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .busRdata   (busRdata),
    .busErr     (busErr),
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busByteEn  (busByteEn),
    .busWdata   (busWdata),
    .statusWord (statusWord),
    .hostRdata  (hostRdata)
  );

  assign busReq = busy;
endmodule

// File: rtl/cmdbus_bridge_chk.sv
module cmdbus_bridge_chk
  import cmdbus_bridge_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        hostWe,
  input logic [1:0]  hostAddr,
  input logic [63:0] hostWdata,
  input logic        busReq,
  input logic        busAck,
  input logic [31:0] busAddr,
  input logic [63:0] statusWord
);
  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr));

  // R4
  ack_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> !busReq && statusWord[ST_DONE] && !statusWord[ST_BUSY]);

  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && hostWe && hostAddr == 2'(OFS_CTL) |=> $stable(busAddr));

  // R6
  reject_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq && hostWe && hostAddr == 2'(OFS_CTL) && hostWdata[KEY_HI:KEY_LO] != CMD_KEY
    |=> !busReq && statusWord[ST_DONE] && statusWord[ST_KEY]);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWord[ST_BUSY] && statusWord[ST_DONE]));
endmodule

bind cmdbus_bridge cmdbus_bridge_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWe     (hostWe),
  .hostAddr   (hostAddr),
  .hostWdata  (hostWdata),
  .busReq     (busReq),
  .busAck     (busAck),
  .busAddr    (busAddr),
  .statusWord (statusWord)
);

// File: tb/test_cmdbus_bridge.sv
module test_cmdbus_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [63:0] hostWdata = '0;
  logic [63:0] hostRdata;
  logic        busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic [3:0]  busByteEn;
  logic [31:0] busRdata = '0;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  cmdbus_bridge i_cmdbus_bridge (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busReq(busReq),
    .busWe(busWe), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .busErr(busErr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkCtl(input logic [3:0] key, input logic [3:0] size,
                                        input bit rd, input logic [2:0] alen, input logic [31:0] addr);
    logic [63:0] w = '0;
    w[63:60] = key;
    w[59:56] = size;
    w[48]    = rd;
    w[40:38] = alen;
    w[31:0]  = addr;
    return w;
  endfunction

  task automatic regWr(input int a, input logic [63:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 2'(a); hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic regRd(input int a, output logic [63:0] d);
    hostAddr = 2'(a);
    #1;
    d = hostRdata;
  endtask

  task automatic serve(input int lat, input logic [31:0] rd, input bit err);
    repeat (lat) @(negedge clk);
    busAck = 1'b1; busRdata = rd; busErr = err;
    @(negedge clk);
    busAck = 1'b0; busErr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [63:0] s, d;
    logic [31:0] a, rv, mask;
    int idx;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busReq == 1'b0, "R1 busReq", 64'(busReq), 64'd0);
    regRd(2, s); chk(s == 64'd0, "R1 status", s, 64'd0);
    regRd(3, d); chk(d == 64'd0, "R1 data", d, 64'd0);

    // sweep all size codes, both directions
    idx = 0;
    for (int sz = 0; sz < 16; sz++) begin
      for (int rd = 0; rd < 2; rd++) begin
        bit legal;
        logic [63:0] dw;
        legal = (sz == 1) || (sz == 2) || (sz == 4);
        a  = 32'h4000_0000 + 32'(sz * 64 + rd * 8);
        dw = {32'h9E37_79B9 ^ 32'(idx * 32'h0101_0101), 32'hFFFF_FFFF};
        rv = a ^ 32'h5A3C_96E1;
        regWr(3, dw);
        regWr(0, mkCtl(4'hD, 4'(sz), rd[0], 3'd4, a));
        if (legal) begin
          mask = 32'hFFFF_FFFF << (32 - 8 * sz);
          chk(busReq == 1'b1, "R2 busReq", 64'(busReq), 64'd1);
          chk(busAddr == a, "R2 busAddr", 64'(busAddr), 64'(a));
          chk(busWe == !rd[0], "R2 busWe", 64'(busWe), 64'(!rd[0]));
          chk(busByteEn == 4'(4'hF << (4 - sz)), "R3 byteEn", 64'(busByteEn), 64'(4'(4'hF << (4 - sz))));
          if (rd == 0) chk(busWdata == dw[63:32], "R3 busWdata", 64'(busWdata), 64'(dw[63:32]));
          regRd(2, s);
          chk(s[19] == 1'b1 && s[11] == 1'b0, "R2 busy/done", s, 64'h80000);
          serve(idx % 4, rv, 1'b0);
          regRd(2, s);
          chk(busReq == 1'b0, "R4 busReq drop", 64'(busReq), 64'd0);
          chk(s[11] == 1'b1 && s[19] == 1'b0, "R4 done", s, 64'h800);
          chk(s[57:26] == (rd ? (rv & mask) : 32'd0), "R5 read field",
              64'(s[57:26]), 64'(rd ? (rv & mask) : 32'd0));
          chk({s[63:58], s[18:12], s[10:8]} == 16'd0, "R5 no errors", s, 64'd0);
        end else begin
          chk(busReq == 1'b0, "R6 no access size", 64'(busReq), 64'd0);
          regRd(2, s);
          chk(s[11] == 1'b1 && s[17] == 1'b1 && s[19] == 1'b0, "R6 size error", s, 64'h20800);
        end
        idx++;
      end
    end

    // R6 bad key, then R9 clear on next accepted command
    regWr(0, mkCtl(4'hC, 4'd4, 1'b0, 3'd4, 32'h10));
    chk(busReq == 1'b0, "R6 key no access", 64'(busReq), 64'd0);
    regRd(2, s); chk(s[18] == 1'b1 && s[11] == 1'b1, "R6 key error", s, 64'h40800);
    repeat (5) @(negedge clk);
    regRd(2, s); chk(s[18] == 1'b1 && s[11] == 1'b1, "R9 done holds", s, 64'h40800);
    regWr(0, mkCtl(4'hD, 4'd4, 1'b0, 3'd3, 32'h20));
    chk(busReq == 1'b0, "R6 alen no access", 64'(busReq), 64'd0);
    regRd(2, s); chk(s[16] == 1'b1 && s[18] == 1'b0 && s[11] == 1'b1, "R6 alen error", s, 64'h10800);
    regWr(0, mkCtl(4'hD, 4'd2, 1'b1, 3'd4, 32'h30));
    regRd(2, s); chk(s[16] == 1'b0 && s[11] == 1'b0 && s[19] == 1'b1, "R9 cleared", s, 64'h80000);
    serve(1, 32'hDEAD_BEEF, 1'b0);

    // R7 bus error response
    regWr(0, mkCtl(4'hD, 4'd4, 1'b1, 3'd4, 32'h0000_00EE));
    serve(2, 32'h1234_5678, 1'b1);
    regRd(2, s);
    chk(s[63] == 1'b1 && s[11] == 1'b1 && s[57:26] == 32'd0, "R7 bus error", s, 64'h8000_0000_0000_0800);

    // R8 ignore control write while busy
    regWr(0, mkCtl(4'hD, 4'd1, 1'b0, 3'd4, 32'hAAAA_0001));
    regWr(0, mkCtl(4'hD, 4'd4, 1'b1, 3'd4, 32'hBBBB_0002));
    chk(busAddr == 32'hAAAA_0001, "R8 address kept", 64'(busAddr), 64'hAAAA_0001);
    chk(busWe == 1'b1 && busByteEn == 4'b1000, "R8 kind kept", 64'({busWe, busByteEn}), 64'h18);
    serve(0, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    chk(busReq == 1'b0, "R8 no second access", 64'(busReq), 64'd0);
    regRd(0, d); chk(d[31:0] == 32'hAAAA_0001, "R8 ctl readback", d, 64'hAAAA_0001);

    // R10 data write during busy
    regWr(3, 64'h1111_2222_3333_4444);
    regWr(0, mkCtl(4'hD, 4'd4, 1'b0, 3'd4, 32'h50));
    regWr(3, 64'h5555_6666_7777_8888);
    chk(busWdata == 32'h1111_2222, "R10 wdata held", 64'(busWdata), 64'h1111_2222);
    regRd(3, d); chk(d == 64'h5555_6666_7777_8888, "R10 readback", d, 64'h5555_6666_7777_8888);
    serve(1, 32'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule